// File: doc/BRIEF.md
# Five-stage pipelined load/store core

This block is a small in-order 32-bit processor core split into five stages: fetch, decode with register read, execute, memory access and write-back. A register separates each pair of neighbouring stages and holds what the earlier stage produced on the previous cycle. Every instruction walks through all five stages, even where a stage has nothing to do for it. As a result, one instruction can complete per cycle once the pipe is full, and every instruction has the same latency.

The core runs five operations: word load, word store, add, subtract and bitwise OR. Instruction memory and data memory are word-indexed arrays inside the block. They are filled through load ports while reset is held. The block has no hazard detection, no forwarding and no branches. Code must place enough all-zero no-op words between a producer and its consumer. The register file can be read through a peek port, and every register write is shown on a write-back observation port.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high the PC is 0 and every pipeline register is invalid. All 32 registers read zero after reset. `wb_en_o` stays low for the first four rising edges after reset is released.
- R2: The instruction in instruction word k shows `wb_en_o`, `wb_rd_o` and `wb_data_o` during the cycle after the (k+4)th rising edge once reset is released.
- R3: An instruction with opcode bits 31:26 = 0 writes register rd (bits 15:11) with rs (bits 25:21) op rt (bits 20:16). Funct bits 5:0 select the op: 0x20 add, 0x22 subtract (rs minus rt), 0x25 OR.
- R4: Opcode 0x23 loads the data word at byte address R[rs] + sign-extended bits 15:0 into register rt. The word index is address bits [DA_W+1:2].
- R5: Opcode 0x2B stores R[rt] to the data word at byte address R[rs] + sign-extended bits 15:0.
- R6: Each write-back uses the destination register carried down with that same instruction, even when the next instructions name other registers.
- R7: A value written back is seen by an instruction decoded in the same cycle. Two no-ops between a producer and its consumer are therefore enough.
- R8: Register 0 always reads as zero, and writes to it, whether from a load or from arithmetic, are discarded.
- R9: The all-zero word, an opcode 0 word with any funct other than 0x20, 0x22 or 0x25, and any opcode other than 0x00, 0x23 or 0x2B change no register and no memory word. Arithmetic never writes data memory.
- R10: The PC advances by 4 on every cycle out of reset, so instruction words are fetched in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_ld_we | input | 1 | Write enable for instruction memory fill |
| imem_ld_addr | input | IA_W | Instruction word index to fill |
| imem_ld_data | input | 32 | Instruction word to fill |
| dmem_ld_we | input | 1 | Write enable for data memory fill |
| dmem_ld_addr | input | DA_W | Data word index to fill |
| dmem_ld_data | input | 32 | Data word to fill |
| dmem_peek_addr | input | DA_W | Data word index to observe |
| dmem_peek_data | output | 32 | Data word at dmem_peek_addr |
| rf_peek_addr | input | 5 | Register number to observe |
| rf_peek_data | output | 32 | Register contents (register 0 reads zero) |
| wb_en_o | output | 1 | A register write occurs this cycle |
| wb_rd_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |

## Verification
The hardest case to reach from the ports is the cycle in which a load is in write-back while a dependent instruction is in decode. The consumer must pick up the value in that same cycle. The stimulus reaches it by placing exactly two no-op words between the producer and its consumers, and it does so several times in a chain. A separate scenario loads six registers back to back and samples the write-back port on every cycle. This pins the latency, the fetch order and the destination each instruction carries.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
   localparam int unsigned XLEN   = 32;
   localparam int unsigned RIDX_W = 5;
   localparam int unsigned NREG   = 1 << RIDX_W;

   localparam logic [5:0] OPC_REG = 6'h00;
   localparam logic [5:0] OPC_LDW = 6'h23;
   localparam logic [5:0] OPC_STW = 6'h2B;
   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_OR   = 6'h25;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    rf_we;
      logic    mem_rd;
      logic    mem_wr;
      logic    use_imm;
      alu_op_e alu;
   } ctl_t;

   typedef struct packed {
      logic            valid;
      logic [XLEN-1:0] instr;
   } ifid_t;

   typedef struct packed {
      logic              valid;
      ctl_t              ctl;
      logic [XLEN-1:0]   opa;
      logic [XLEN-1:0]   opb;
      logic [XLEN-1:0]   imm;
      logic [RIDX_W-1:0] dst;
   } idex_t;

   typedef struct packed {
      logic              valid;
      logic              rf_we;
      logic              mem_rd;
      logic              mem_wr;
      logic [XLEN-1:0]   res;
      logic [XLEN-1:0]   sdata;
      logic [RIDX_W-1:0] dst;
   } exmem_t;

   typedef struct packed {
      logic              valid;
      logic              rf_we;
      logic              mem_rd;
      logic [XLEN-1:0]   res;
      logic [XLEN-1:0]   ldata;
      logic [RIDX_W-1:0] dst;
   } memwb_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
   import pipe5_pkg::*;
(
   input  logic [XLEN-1:0]   instr_i,
   output logic [RIDX_W-1:0] rs_o,
   output logic [RIDX_W-1:0] rt_o,
   output logic [RIDX_W-1:0] dst_o,
   output logic [XLEN-1:0]   imm_o,
   output ctl_t              ctl_o
);
   logic [5:0]  opc;
   logic [5:0]  fn;
   logic [15:0] imm16;

   assign opc   = instr_i[31:26];
   assign rs_o  = instr_i[25:21];
   assign rt_o  = instr_i[20:16];
   assign fn    = instr_i[5:0];
   assign imm16 = instr_i[15:0];
   assign imm_o = {{(XLEN-16){imm16[15]}}, imm16};

   always_comb begin
      ctl_o = '0;
      dst_o = instr_i[15:11];
      case (opc)
         OPC_REG: begin
            case (fn)
               FN_ADD: begin ctl_o.rf_we = 1'b1; ctl_o.alu = ALU_ADD; end
               FN_SUB: begin ctl_o.rf_we = 1'b1; ctl_o.alu = ALU_SUB; end
               FN_OR:  begin ctl_o.rf_we = 1'b1; ctl_o.alu = ALU_OR;  end
               default: ctl_o = '0;
            endcase
         end
         OPC_LDW: begin
            ctl_o.rf_we   = 1'b1;
            ctl_o.mem_rd  = 1'b1;
            ctl_o.use_imm = 1'b1;
            ctl_o.alu     = ALU_ADD;
            dst_o         = instr_i[20:16];
         end
         OPC_STW: begin
            ctl_o.mem_wr  = 1'b1;
            ctl_o.use_imm = 1'b1;
            ctl_o.alu     = ALU_ADD;
            dst_o         = instr_i[20:16];
         end
         default: ctl_o = '0;
      endcase
   end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
   import pipe5_pkg::*;
(
   input  alu_op_e         op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] y_o
);
   always_comb begin
      case (op_i)
         ALU_SUB: y_o = a_i - b_i;
         ALU_OR:  y_o = a_i | b_i;
         default: y_o = a_i + b_i;
      endcase
   end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
   import pipe5_pkg::*;
#(
   parameter int unsigned NRD        = 3,
   parameter bit          WRITE_THRU = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we_i,
   input  logic [RIDX_W-1:0]      wa_i,
   input  logic [XLEN-1:0]        wd_i,
   input  logic [NRD*RIDX_W-1:0]  ra_i,
   output logic [NRD*XLEN-1:0]    rd_o
);
   if (NRD < 1 || NRD > 8) begin : g_bad_nrd
      $error("pipe5_regfile: NRD must be 1..8");
   end

   logic [XLEN-1:0] regs_q [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      end else if (we_i && wa_i != '0) begin
         regs_q[wa_i] <= wd_i;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      logic [RIDX_W-1:0] addr;
      assign addr = ra_i[g*RIDX_W +: RIDX_W];
      if (WRITE_THRU) begin : g_thru
         assign rd_o[g*XLEN +: XLEN] = (addr == '0) ? '0 :
                                       (we_i && wa_i == addr) ? wd_i : regs_q[addr];
      end else begin : g_plain
         assign rd_o[g*XLEN +: XLEN] = (addr == '0) ? '0 : regs_q[addr];
      end
   end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int unsigned IMEM_WORDS    = 64,
   parameter int unsigned DMEM_WORDS    = 64,
   parameter bit          RF_WRITE_THRU = 1'b1,
   localparam int unsigned IA_W = $clog2(IMEM_WORDS),
   localparam int unsigned DA_W = $clog2(DMEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              imem_ld_we,
   input  logic [IA_W-1:0]   imem_ld_addr,
   input  logic [31:0]       imem_ld_data,
   input  logic              dmem_ld_we,
   input  logic [DA_W-1:0]   dmem_ld_addr,
   input  logic [31:0]       dmem_ld_data,
   input  logic [DA_W-1:0]   dmem_peek_addr,
   output logic [31:0]       dmem_peek_data,
   input  logic [4:0]        rf_peek_addr,
   output logic [31:0]       rf_peek_data,
   output logic              wb_en_o,
   output logic [4:0]        wb_rd_o,
   output logic [31:0]       wb_data_o
);
   if (IMEM_WORDS < 2 || IMEM_WORDS > 4096 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0) begin : g_bad_imem
      $error("pipe5_core: IMEM_WORDS must be a power of two in 2..4096");
   end
   if (DMEM_WORDS < 2 || DMEM_WORDS > 4096 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0) begin : g_bad_dmem
      $error("pipe5_core: DMEM_WORDS must be a power of two in 2..4096");
   end

   logic [XLEN-1:0] imem_q [IMEM_WORDS];
   logic [XLEN-1:0] dmem_q [DMEM_WORDS];
   logic [XLEN-1:0] pc_q;
   ifid_t           ifid_q;
   idex_t           idex_q;
   exmem_t          exmem_q;
   memwb_t          memwb_q;

   // ---------------- fetch ----------------
   always_ff @(posedge clk) begin
      if (imem_ld_we) imem_q[imem_ld_addr] <= imem_ld_data;
   end

   logic [XLEN-1:0] fetch_word;
   assign fetch_word = imem_q[pc_q[IA_W+1:2]];

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         ifid_q <= '0;
      end else begin
         pc_q         <= pc_q + 32'd4;
         ifid_q.valid <= 1'b1;
         ifid_q.instr <= fetch_word;
      end
   end

   // ---------------- decode / register read ----------------
   logic [RIDX_W-1:0] dec_rs, dec_rt, dec_dst;
   logic [XLEN-1:0]   dec_imm;
   ctl_t              dec_ctl;
   logic [XLEN-1:0]   rs_data, rt_data;
   logic [3*XLEN-1:0] rf_rd;
   logic              wb_en;
   logic [XLEN-1:0]   wb_data;

   pipe5_decode u_dec (
      .instr_i (ifid_q.instr),
      .rs_o    (dec_rs),
      .rt_o    (dec_rt),
      .dst_o   (dec_dst),
      .imm_o   (dec_imm),
      .ctl_o   (dec_ctl)
   );

   pipe5_regfile #(.NRD(3), .WRITE_THRU(RF_WRITE_THRU)) u_rf (
      .clk  (clk),
      .rst  (rst),
      .we_i (wb_en),
      .wa_i (memwb_q.dst),
      .wd_i (wb_data),
      .ra_i ({rf_peek_addr, dec_rt, dec_rs}),
      .rd_o (rf_rd)
   );

   assign rs_data      = rf_rd[0*XLEN +: XLEN];
   assign rt_data      = rf_rd[1*XLEN +: XLEN];
   assign rf_peek_data = rf_rd[2*XLEN +: XLEN];

   always_ff @(posedge clk) begin
      if (rst) begin
         idex_q <= '0;
      end else begin
         idex_q.valid <= ifid_q.valid;
         idex_q.ctl   <= ifid_q.valid ? dec_ctl : '0;
         idex_q.opa   <= rs_data;
         idex_q.opb   <= rt_data;
         idex_q.imm   <= dec_imm;
         idex_q.dst   <= dec_dst;
      end
   end

   // ---------------- execute ----------------
   logic [XLEN-1:0] alu_b, alu_y;
   assign alu_b = idex_q.ctl.use_imm ? idex_q.imm : idex_q.opb;

   pipe5_alu u_alu (
      .op_i (idex_q.ctl.alu),
      .a_i  (idex_q.opa),
      .b_i  (alu_b),
      .y_o  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         exmem_q <= '0;
      end else begin
         exmem_q.valid  <= idex_q.valid;
         exmem_q.rf_we  <= idex_q.ctl.rf_we;
         exmem_q.mem_rd <= idex_q.ctl.mem_rd;
         exmem_q.mem_wr <= idex_q.ctl.mem_wr;
         exmem_q.res    <= alu_y;
         exmem_q.sdata  <= idex_q.opb;
         exmem_q.dst    <= idex_q.dst;
      end
   end

   // ---------------- memory ----------------
   logic [DA_W-1:0] dm_idx;
   logic [XLEN-1:0] dm_rdata;
   logic            dmem_we;

   assign dm_idx   = exmem_q.res[DA_W+1:2];
   assign dm_rdata = dmem_q[dm_idx];
   assign dmem_we  = exmem_q.valid && exmem_q.mem_wr;

   always_ff @(posedge clk) begin
      if (dmem_ld_we)   dmem_q[dmem_ld_addr] <= dmem_ld_data;
      else if (dmem_we) dmem_q[dm_idx]       <= exmem_q.sdata;
   end

   assign dmem_peek_data = dmem_q[dmem_peek_addr];

   always_ff @(posedge clk) begin
      if (rst) begin
         memwb_q <= '0;
      end else begin
         memwb_q.valid  <= exmem_q.valid;
         memwb_q.rf_we  <= exmem_q.rf_we;
         memwb_q.mem_rd <= exmem_q.mem_rd;
         memwb_q.res    <= exmem_q.res;
         memwb_q.ldata  <= dm_rdata;
         memwb_q.dst    <= exmem_q.dst;
      end
   end

   // ---------------- write-back ----------------
   assign wb_data = memwb_q.mem_rd ? memwb_q.ldata : memwb_q.res;
   assign wb_en   = memwb_q.valid && memwb_q.rf_we && (memwb_q.dst != '0);

   assign wb_en_o   = wb_en;
   assign wb_rd_o   = memwb_q.dst;
   assign wb_data_o = wb_data;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic        ifid_valid,
   input logic        idex_store,
   input logic [4:0]  exmem_dst,
   input logic [4:0]  memwb_dst,
   input logic        dmem_we,
   input logic [4:0]  dec_rs,
   input logic [31:0] rs_data,
   input logic        wb_en
);
   p_fill_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !wb_en);

   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> $past(ifid_valid, 3));

   p_dest_carry_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> memwb_dst == $past(exmem_dst));

   p_r0_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (dec_rs == 5'd0) |-> rs_data == 32'd0);

   p_store_only_r9: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> $past(idex_store));

   p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> pc == $past(pc) + 32'd4);
endmodule

bind pipe5_core pipe5_core_chk chk_i (
   .clk        (clk),
   .rst        (rst),
   .pc         (pc_q),
   .ifid_valid (ifid_q.valid),
   .idex_store (idex_q.valid && idex_q.ctl.mem_wr),
   .exmem_dst  (exmem_q.dst),
   .memwb_dst  (memwb_q.dst),
   .dmem_we    (dmem_we),
   .dec_rs     (dec_rs),
   .rs_data    (rs_data),
   .wb_en      (wb_en)
);

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int IMW = 64;
   localparam int DMW = 64;
   localparam int IAW = 6;
   localparam int DAW = 6;
   localparam int RUN_CYCLES = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic           imem_ld_we = 1'b0;
   logic [IAW-1:0] imem_ld_addr = '0;
   logic [31:0]    imem_ld_data = '0;
   logic           dmem_ld_we = 1'b0;
   logic [DAW-1:0] dmem_ld_addr = '0;
   logic [31:0]    dmem_ld_data = '0;
   logic [DAW-1:0] dmem_peek_addr = '0;
   logic [31:0]    dmem_peek_data;
   logic [4:0]     rf_peek_addr = '0;
   logic [31:0]    rf_peek_data;
   logic           wb_en_o;
   logic [4:0]     wb_rd_o;
   logic [31:0]    wb_data_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe5_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) dut_i (
      .clk(clk), .rst(rst),
      .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
      .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
      .dmem_peek_addr(dmem_peek_addr), .dmem_peek_data(dmem_peek_data),
      .rf_peek_addr(rf_peek_addr), .rf_peek_data(rf_peek_data),
      .wb_en_o(wb_en_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
   );

   int n_checks = 0;
   int n_errors = 0;
   logic [31:0] prog   [IMW];
   logic [31:0] dinit  [DMW];
   logic [31:0] ref_rf [32];
   logic [31:0] ref_dm [DMW];

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                         input logic [4:0] rs, input logic [4:0] rt);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                         input logic [4:0] rs, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < IMW; i++) prog[i] = 32'd0;
      for (int i = 0; i < DMW; i++) dinit[i] = 32'h1000_0000 + i;
   endtask

   task automatic load_and_release();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < IMW; i++) begin
         imem_ld_we = 1'b1; imem_ld_addr = IAW'(i); imem_ld_data = prog[i];
         @(negedge clk);
      end
      imem_ld_we = 1'b0;
      for (int i = 0; i < DMW; i++) begin
         dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_data = dinit[i];
         @(negedge clk);
      end
      dmem_ld_we = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // sequential reference: no-ops guarantee no overlap between dependent instructions
   task automatic run_model();
      for (int r = 0; r < 32; r++) ref_rf[r] = 32'd0;
      for (int d = 0; d < DMW; d++) ref_dm[d] = dinit[d];
      for (int i = 0; i < RUN_CYCLES - 5; i++) begin
         logic [31:0] w, sx, addr;
         logic [4:0] rs, rt, rd;
         w  = prog[i];
         rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
         sx = {{16{w[15]}}, w[15:0]};
         addr = ref_rf[rs] + sx;
         case (w[31:26])
            6'h00: begin
               if (w[5:0] == 6'h20 && rd != 0) ref_rf[rd] = ref_rf[rs] + ref_rf[rt];
               if (w[5:0] == 6'h22 && rd != 0) ref_rf[rd] = ref_rf[rs] - ref_rf[rt];
               if (w[5:0] == 6'h25 && rd != 0) ref_rf[rd] = ref_rf[rs] | ref_rf[rt];
            end
            6'h23: if (rt != 0) ref_rf[rt] = ref_dm[addr[DAW+1:2]];
            6'h2B: ref_dm[addr[DAW+1:2]] = ref_rf[rt];
            default: ;
         endcase
      end
   endtask

   task automatic compare_all(input string req);
      for (int r = 0; r < 32; r++) begin
         rf_peek_addr = 5'(r);
         #1;
         check(req, $sformatf("reg %0d", r), rf_peek_data, ref_rf[r]);
      end
      for (int d = 0; d < DMW; d++) begin
         dmem_peek_addr = DAW'(d);
         #1;
         check(req, $sformatf("mem word %0d", d), dmem_peek_data, ref_dm[d]);
      end
   endtask

   task automatic peek_reg(input int r, output logic [31:0] v);
      rf_peek_addr = 5'(r); #1; v = rf_peek_data;
   endtask

   task automatic peek_mem(input int d, output logic [31:0] v);
      dmem_peek_addr = DAW'(d); #1; v = dmem_peek_data;
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      clear_prog();
      load_and_release();
      for (int c = 1; c <= 6; c++) begin
         @(negedge clk);
         check("R1", $sformatf("wb_en cycle %0d (all no-ops)", c), 32'(wb_en_o), 32'd0);
      end
      for (int r = 0; r < 32; r++) begin
         peek_reg(r, v);
         check("R1", $sformatf("reg %0d after reset", r), v, 32'd0);
      end
   endtask

   task automatic t_stream();
      clear_prog();
      for (int k = 0; k < 6; k++) begin
         prog[k]  = enc_i(6'h23, 5'(k + 1), 5'd0, 16'(k * 4));
         dinit[k] = 32'hA000_0000 + 32'(k * 17);
      end
      load_and_release();
      for (int c = 1; c <= 10; c++) begin
         @(negedge clk);
         if (c < 4) begin
            check("R1", $sformatf("wb_en quiet after edge %0d", c), 32'(wb_en_o), 32'd0);
         end else if (c <= 9) begin
            check("R2", $sformatf("wb_en for word %0d", c - 4), 32'(wb_en_o), 32'd1);
            check("R6", $sformatf("wb_rd for word %0d", c - 4), 32'(wb_rd_o), 32'(c - 3));
            check("R10", $sformatf("wb_data order word %0d", c - 4), wb_data_o,
                  32'hA000_0000 + 32'((c - 4) * 17));
         end else begin
            check("R2", "wb_en low after last load", 32'(wb_en_o), 32'd0);
         end
      end
      repeat (RUN_CYCLES - 10) @(negedge clk);
      run_model();
      compare_all("R6");
   endtask

   task automatic t_arith();
      logic [31:0] v;
      clear_prog();
      dinit[0] = 32'd100;
      dinit[1] = 32'h0F0F_0033;
      prog[0]  = enc_i(6'h23, 5'd1, 5'd0, 16'd0);
      prog[1]  = enc_i(6'h23, 5'd2, 5'd0, 16'd4);
      prog[5]  = enc_r(6'h20, 5'd3, 5'd1, 5'd2);
      prog[6]  = enc_r(6'h22, 5'd4, 5'd1, 5'd2);
      prog[7]  = enc_r(6'h22, 5'd5, 5'd2, 5'd1);
      prog[8]  = enc_r(6'h25, 5'd6, 5'd1, 5'd2);
      prog[12] = enc_i(6'h2B, 5'd3, 5'd0, 16'd16);
      load_and_release();
      repeat (RUN_CYCLES) @(negedge clk);
      peek_reg(3, v); check("R3", "add", v, 32'd100 + 32'h0F0F_0033);
      peek_reg(4, v); check("R3", "sub rs-rt", v, 32'd100 - 32'h0F0F_0033);
      peek_reg(5, v); check("R3", "sub reversed", v, 32'h0F0F_0033 - 32'd100);
      peek_reg(6, v); check("R3", "or", v, 32'd100 | 32'h0F0F_0033);
      run_model();
      compare_all("R3");
   endtask

   task automatic t_mem();
      logic [31:0] v;
      clear_prog();
      dinit[4]  = 32'h0000_0040;
      dinit[14] = 32'hCAFE_F00D;
      prog[0] = enc_i(6'h23, 5'd7, 5'd0, 16'd16);
      prog[4] = enc_i(6'h23, 5'd8, 5'd7, 16'hFFF8);
      prog[8] = enc_i(6'h2B, 5'd8, 5'd7, 16'd12);
      prog[9] = enc_i(6'h2B, 5'd7, 5'd7, 16'hFFFC);
      load_and_release();
      repeat (RUN_CYCLES) @(negedge clk);
      peek_reg(8, v);  check("R4", "load with negative offset", v, 32'hCAFE_F00D);
      peek_mem(19, v); check("R5", "store positive offset", v, 32'hCAFE_F00D);
      peek_mem(15, v); check("R5", "store negative offset", v, 32'h0000_0040);
      run_model();
      compare_all("R4");
   endtask

   task automatic t_tight();
      logic [31:0] v;
      clear_prog();
      dinit[0] = 32'h0000_1234;
      prog[0] = enc_i(6'h23, 5'd1, 5'd0, 16'd0);
      prog[3] = enc_r(6'h20, 5'd2, 5'd1, 5'd1);
      prog[6] = enc_r(6'h20, 5'd3, 5'd2, 5'd1);
      prog[9] = enc_i(6'h2B, 5'd3, 5'd0, 16'd8);
      load_and_release();
      repeat (RUN_CYCLES) @(negedge clk);
      peek_reg(2, v);  check("R7", "consumer two no-ops after load", v, 32'h0000_2468);
      peek_reg(3, v);  check("R7", "second link of chain", v, 32'h0000_369C);
      peek_mem(2, v);  check("R7", "store two no-ops after producer", v, 32'h0000_369C);
      run_model();
      compare_all("R7");
   endtask

   task automatic t_r0();
      logic [31:0] v;
      clear_prog();
      dinit[0] = 32'h0000_0055;
      dinit[1] = 32'h0000_FFFF;
      prog[0] = enc_i(6'h23, 5'd0, 5'd0, 16'd0);
      prog[1] = enc_i(6'h23, 5'd1, 5'd0, 16'd0);
      prog[5] = enc_r(6'h20, 5'd0, 5'd1, 5'd1);
      prog[9] = enc_r(6'h20, 5'd9, 5'd0, 5'd1);
      prog[10] = enc_i(6'h2B, 5'd0, 5'd0, 16'd4);
      load_and_release();
      repeat (RUN_CYCLES) @(negedge clk);
      peek_reg(0, v); check("R8", "reg 0 after writes", v, 32'd0);
      peek_reg(9, v); check("R8", "reg 0 as operand", v, 32'h0000_0055);
      peek_mem(1, v); check("R8", "store of reg 0", v, 32'd0);
      run_model();
      compare_all("R8");
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      clear_prog();
      dinit[0] = 32'd7;
      prog[0] = enc_i(6'h23, 5'd1, 5'd0, 16'd0);
      prog[4] = enc_r(6'h3F, 5'd10, 5'd1, 5'd1);
      prog[5] = enc_i(6'h3F, 5'd11, 5'd1, 16'd4);
      prog[6] = enc_r(6'h00, 5'd13, 5'd1, 5'd1);
      prog[7] = enc_r(6'h20, 5'd12, 5'd1, 5'd1);
      load_and_release();
      repeat (RUN_CYCLES) @(negedge clk);
      peek_reg(10, v); check("R9", "unknown funct", v, 32'd0);
      peek_reg(11, v); check("R9", "unknown opcode", v, 32'd0);
      peek_reg(13, v); check("R9", "funct zero", v, 32'd0);
      peek_reg(12, v); check("R9", "arith after ignored words", v, 32'd14);
      for (int d = 0; d < DMW; d++) begin
         peek_mem(d, v);
         check("R9", $sformatf("mem word %0d untouched", d), v, dinit[d]);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_stream();
      t_arith();
      t_mem();
      t_tight();
      t_r0();
      t_ignored();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule